// File: doc/BRIEF.md
# Configuration Transaction Type Decoder

This block watches the address phase of a bus transaction on the upstream (primary) port of a bridge and decides what kind of configuration access it is. When the address-phase strobe is high and the command code is a configuration read or a configuration write, the two least significant address bits pick the format. One value marks a local access to a device on this bus. Another value marks a hierarchical access meant for a bus further down. The two remaining values are malformed. The block also splits the address word into its register, function, device and bus fields.

For a well-formed local access that arrives on the upstream port and has the bridge's own select line high, the block raises a one-cycle device-select response. That response is registered and appears in the cycle after the strobe. A local access that comes in from the downstream side is never claimed. A hierarchical access is classified only. Forwarding it and generating special cycles belong to other blocks.

All of the classification and field outputs are registered results. They are valid for one cycle, flagged by `dec_vld`. The block takes a new address phase every cycle and never pushes back on its source. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure rule. A caller must sample each result in the cycle it is presented.

Top module: `cfg_type_decoder`

## Requirements
- R1: A strobed command 1010b or 1011b with address bits [1:0] = 00b raises `dec_vld` and `is_type0`, and nothing else of the kind flags, in the next cycle.
- R2: A strobed command 1010b or 1011b with address bits [1:0] = 01b raises `dec_vld` and `is_type1` in the next cycle, and `dev_sel` stays low.
- R3: A strobed command 1010b or 1011b with address bits [1:0] = 10b or 11b raises `dec_vld` and `is_bad` in the next cycle, and `dev_sel` stays low.
- R4: A strobed command other than 1010b or 1011b leaves every output low/zero in the next cycle.
- R5: With `dec_vld` high, `reg_num` = address [7:2], `dev_num` = address [15:11] and `bus_num` = address [23:16] of the strobed address. These fields are zero while `dec_vld` is low.
- R6: With the default single-function setting (`NUM_FUNC` = 1), `func_num` reads zero and the function bits [10:8] have no effect on `dev_sel`.
- R7: `dev_sel` is high for exactly the cycle after a strobe whose command is a configuration read/write, with bits [1:0] = 00b, `from_secondary` low and `own_sel` high.
- R8: A Type 0 access with `from_secondary` high never raises `dev_sel`.
- R9: When `addr_stb` is low, all outputs are low/zero in the next cycle.
- R10: After reset, and before any strobe, all outputs are low/zero.
- R11: With `NUM_FUNC` > 1, `func_num` = address [10:8], and a Type 0 access is claimed only when that value is below `NUM_FUNC`.
- R12: Strobes on consecutive cycles each produce their own result, one cycle apart, with no mixing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_stb | input | 1 | High during an address phase |
| cmd | input | 4 | Bus command code |
| addr | input | 32 | Address word of the address phase |
| from_secondary | input | 1 | High when the request came from the downstream side |
| own_sel | input | 1 | Select line addressing this bridge's own configuration space |
| dec_vld | output | 1 | A configuration command was decoded last cycle |
| is_type0 | output | 1 | Decoded access is the local format |
| is_type1 | output | 1 | Decoded access is the hierarchical format |
| is_bad | output | 1 | Decoded access has a reserved low-bit code |
| dev_sel | output | 1 | Device-select claim for the bridge's own space |
| reg_num | output | 6 | DWORD register number |
| func_num | output | 3 | Function number (zero for single-function) |
| dev_num | output | 5 | Device number |
| bus_num | output | 8 | Bus number |

## Verification
Two things can fall into the same cycle: the result of one address phase being presented, and the capture of the next address phase. The bench provokes this with back-to-back strobes that differ in format, side and fields. For example, a claimed local access is followed at once by a hierarchical access from the other side. The cycle after each strobe is judged on its own, and that cycle must hold only its own request's flags, fields and claim. A second instance with four functions is run to check that the function number gates the claim and is reported.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_T0   = 2'd1,
    KIND_T1   = 2'd2,
    KIND_BAD  = 2'd3
  } cfg_kind_e;
endpackage

// File: rtl/cfgdec_classify.sv
module cfgdec_classify
  import cfgdec_pkg::*;
#(
  parameter int CMD_W = 4,
  parameter logic [CMD_W-1:0] CMD_RD = 4'b1010,
  parameter logic [CMD_W-1:0] CMD_WR = 4'b1011
) (
  input  logic [CMD_W-1:0] cmd,
  input  logic [1:0]       low_bits,
  output cfg_kind_e        kind
);
  logic is_cfg;
  assign is_cfg = (cmd == CMD_RD) || (cmd == CMD_WR);

  always_comb begin
    kind = KIND_NONE;
    if (is_cfg) begin
      case (low_bits)
        2'b00:   kind = KIND_T0;
        2'b01:   kind = KIND_T1;
        default: kind = KIND_BAD;
      endcase
    end
  end
endmodule

// File: rtl/cfgdec_fields.sv
module cfgdec_fields #(
  parameter int ADDR_W   = 32,
  parameter int REG_LSB  = 2,
  parameter int REG_W    = 6,
  parameter int FUNC_W   = 3,
  parameter int DEV_W    = 5,
  parameter int BUS_W    = 8,
  parameter int NUM_FUNC = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [REG_W-1:0]  reg_f,
  output logic [FUNC_W-1:0] func_f,
  output logic [DEV_W-1:0]  dev_f,
  output logic [BUS_W-1:0]  bus_f,
  output logic              func_ok
);
  localparam int FUNC_LSB = REG_LSB + REG_W;
  localparam int DEV_LSB  = FUNC_LSB + FUNC_W;
  localparam int BUS_LSB  = DEV_LSB + DEV_W;
  localparam int TOP_BIT  = BUS_LSB + BUS_W;

  assign reg_f = addr[FUNC_LSB-1:REG_LSB];
  assign dev_f = addr[BUS_LSB-1:DEV_LSB];
  assign bus_f = addr[TOP_BIT-1:BUS_LSB];

  logic unused_addr_bits;
  assign unused_addr_bits = ^{addr[ADDR_W-1:TOP_BIT], addr[REG_LSB-1:0]};

  generate
    if (NUM_FUNC > 1) begin : g_multi
      localparam logic [FUNC_W:0] NF = NUM_FUNC[FUNC_W:0];
      assign func_f  = addr[DEV_LSB-1:FUNC_LSB];
      assign func_ok = ({1'b0, addr[DEV_LSB-1:FUNC_LSB]} < NF);
    end else begin : g_single
      logic unused_func_bits;
      assign unused_func_bits = ^addr[DEV_LSB-1:FUNC_LSB];
      assign func_f  = '0;
      assign func_ok = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/cfgdec_claim.sv
module cfgdec_claim
  import cfgdec_pkg::*;
(
  input  logic      stb,
  input  cfg_kind_e kind,
  input  logic      from_sec,
  input  logic      own_sel,
  input  logic      func_ok,
  output logic      claim
);
  always_comb begin
    claim = 1'b0;
    if (stb && kind == KIND_T0 && !from_sec && own_sel && func_ok)
      claim = 1'b1;
  end
endmodule

// File: rtl/cfg_type_decoder.sv
module cfg_type_decoder
  import cfgdec_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CMD_W    = 4,
  parameter int REG_W    = 6,
  parameter int FUNC_W   = 3,
  parameter int DEV_W    = 5,
  parameter int BUS_W    = 8,
  parameter int NUM_FUNC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_stb,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              from_secondary,
  input  logic              own_sel,
  output logic              dec_vld,
  output logic              is_type0,
  output logic              is_type1,
  output logic              is_bad,
  output logic              dev_sel,
  output logic [REG_W-1:0]  reg_num,
  output logic [FUNC_W-1:0] func_num,
  output logic [DEV_W-1:0]  dev_num,
  output logic [BUS_W-1:0]  bus_num
);
  localparam int REG_LSB = 2;

  cfg_kind_e         kind;
  logic [REG_W-1:0]  reg_c;
  logic [FUNC_W-1:0] func_c;
  logic [DEV_W-1:0]  dev_c;
  logic [BUS_W-1:0]  bus_c;
  logic              func_ok;
  logic              claim;
  logic              take;

  cfgdec_classify #(.CMD_W(CMD_W)) u_classify (
    .cmd      (cmd),
    .low_bits (addr[1:0]),
    .kind     (kind)
  );

  cfgdec_fields #(
    .ADDR_W(ADDR_W), .REG_LSB(REG_LSB), .REG_W(REG_W), .FUNC_W(FUNC_W),
    .DEV_W(DEV_W), .BUS_W(BUS_W), .NUM_FUNC(NUM_FUNC)
  ) u_fields (
    .addr    (addr),
    .reg_f   (reg_c),
    .func_f  (func_c),
    .dev_f   (dev_c),
    .bus_f   (bus_c),
    .func_ok (func_ok)
  );

  cfgdec_claim u_claim (
    .stb      (addr_stb),
    .kind     (kind),
    .from_sec (from_secondary),
    .own_sel  (own_sel),
    .func_ok  (func_ok),
    .claim    (claim)
  );

  assign take = addr_stb && (kind != KIND_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_vld  <= 1'b0;
      is_type0 <= 1'b0;
      is_type1 <= 1'b0;
      is_bad   <= 1'b0;
      dev_sel  <= 1'b0;
      reg_num  <= '0;
      func_num <= '0;
      dev_num  <= '0;
      bus_num  <= '0;
    end else begin
      dec_vld  <= take;
      is_type0 <= take && (kind == KIND_T0);
      is_type1 <= take && (kind == KIND_T1);
      is_bad   <= take && (kind == KIND_BAD);
      dev_sel  <= claim;
      reg_num  <= take ? reg_c  : '0;
      func_num <= take ? func_c : '0;
      dev_num  <= take ? dev_c  : '0;
      bus_num  <= take ? bus_c  : '0;
    end
  end
endmodule

// File: rtl/cfg_type_decoder_chk.sv
module cfg_type_decoder_chk #(
  parameter int CMD_W  = 4,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_stb,
  input logic [CMD_W-1:0]  cmd,
  input logic [ADDR_W-1:0] addr,
  input logic              from_secondary,
  input logic              dec_vld,
  input logic              is_type0,
  input logic              is_type1,
  input logic              is_bad,
  input logic              dev_sel
);
  logic         q_stb, q_sec, q_cfg;
  logic [1:0]   q_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_stb <= 1'b0; q_sec <= 1'b0; q_cfg <= 1'b0; q_lo <= 2'b00;
    end else begin
      q_stb <= addr_stb;
      q_sec <= from_secondary;
      q_cfg <= (cmd == 4'b1010) || (cmd == 4'b1011);
      q_lo  <= addr[1:0];
    end
  end

  p_one_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_type0, is_type1, is_bad}));
  p_type1_unclaimed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_type1 |-> !dev_sel);
  p_bad_unclaimed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_bad |-> !dev_sel);
  p_noncfg_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_stb && !q_cfg) |-> (!dec_vld && !dev_sel));
  p_claim_from_t0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_sel |-> (is_type0 && q_lo == 2'b00));
  p_secondary_unclaimed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_stb && q_sec) |-> !dev_sel);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !q_stb |-> (!dec_vld && !dev_sel));
endmodule

bind cfg_type_decoder cfg_type_decoder_chk #(.CMD_W(CMD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .cmd(cmd), .addr(addr),
  .from_secondary(from_secondary), .dec_vld(dec_vld), .is_type0(is_type0),
  .is_type1(is_type1), .is_bad(is_bad), .dev_sel(dev_sel)
);

// File: tb/test_cfg_type_decoder.sv
module test_cfg_type_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0;
  logic [3:0] cmd = 4'h0;
  logic [31:0] addr = 32'h0;
  logic sec = 1'b0;
  logic sel = 1'b0;

  logic vld, t0, t1, bad, dsel;
  logic [5:0] rn; logic [2:0] fn; logic [4:0] dn; logic [7:0] bn;
  logic vld_m, t0_m, t1_m, bad_m, dsel_m;
  logic [5:0] rn_m; logic [2:0] fn_m; logic [4:0] dn_m; logic [7:0] bn_m;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cfg_type_decoder i_cfg_type_decoder (
    .clk(clk), .rst_n(rst_n), .addr_stb(stb), .cmd(cmd), .addr(addr),
    .from_secondary(sec), .own_sel(sel), .dec_vld(vld), .is_type0(t0),
    .is_type1(t1), .is_bad(bad), .dev_sel(dsel), .reg_num(rn),
    .func_num(fn), .dev_num(dn), .bus_num(bn));

  cfg_type_decoder #(.NUM_FUNC(4)) i_cfg_type_decoder_mf (
    .clk(clk), .rst_n(rst_n), .addr_stb(stb), .cmd(cmd), .addr(addr),
    .from_secondary(sec), .own_sel(sel), .dec_vld(vld_m), .is_type0(t0_m),
    .is_type1(t1_m), .is_bad(bad_m), .dev_sel(dsel_m), .reg_num(rn_m),
    .func_num(fn_m), .dev_num(dn_m), .bus_num(bn_m));

  function automatic logic [26:0] model(input logic s, input logic [3:0] c,
      input logic [31:0] a, input logic sd, input logic os, input int nf);
    logic v, k0, k1, kb, ds, fok;
    logic [2:0] f;
    v   = s && (c == 4'b1010 || c == 4'b1011);
    k0  = v && a[1:0] == 2'b00;
    k1  = v && a[1:0] == 2'b01;
    kb  = v && a[1]   == 1'b1;
    f   = (v && nf > 1) ? a[10:8] : 3'd0;
    fok = (nf == 1) || (int'(a[10:8]) < nf);
    ds  = k0 && !sd && os && fok;
    if (!v) return {5'b0, 22'b0};
    return {v, k0, k1, kb, ds, a[7:2], f, a[15:11], a[23:16]};
  endfunction

  task automatic check(input string req, input logic [26:0] got, input logic [26:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [3:0] c, input logic [31:0] a,
      input logic sd, input logic os);
    stb = s; cmd = c; addr = a; sec = sd; sel = os;
  endtask

  // one address phase, then check the cycle after it on the default instance
  task automatic one(input string req, input logic s, input logic [3:0] c,
      input logic [31:0] a, input logic sd, input logic os);
    @(negedge clk); drive(s, c, a, sd, os);
    @(negedge clk); drive(0, 4'h0, 32'h0, 0, 0);
    check(req, {vld, t0, t1, bad, dsel, rn, fn, dn, bn}, model(s, c, a, sd, os, 1));
  endtask

  task automatic t_reset;
    check("R10 reset", {vld, t0, t1, bad, dsel, rn, fn, dn, bn}, 27'h0);
    check("R10 reset mf", {vld_m, t0_m, t1_m, bad_m, dsel_m, rn_m, fn_m, dn_m, bn_m}, 27'h0);
  endtask

  task automatic t_type0;
    one("R1 R7 type0 read claimed", 1, 4'b1010, 32'h0000_0010, 0, 1);
    one("R1 R7 type0 write claimed", 1, 4'b1011, 32'h0000_00FC, 0, 1);
    one("R1 R7 type0 no own_sel", 1, 4'b1010, 32'h0000_0004, 0, 0);
  endtask

  task automatic t_secondary;
    one("R8 type0 from secondary", 1, 4'b1010, 32'h0000_0020, 1, 1);
    one("R8 type0 write from secondary", 1, 4'b1011, 32'h0000_0000, 1, 1);
  endtask

  task automatic t_type1;
    one("R2 type1 read", 1, 4'b1010, 32'h0012_3405, 0, 1);
    one("R2 type1 write", 1, 4'b1011, 32'h00FF_FFFD, 0, 1);
  endtask

  task automatic t_bad;
    one("R3 low bits 10", 1, 4'b1010, 32'h0000_0002, 0, 1);
    one("R3 low bits 11", 1, 4'b1011, 32'h0000_0043, 0, 1);
  endtask

  task automatic t_noncfg;
    one("R4 memory read cmd", 1, 4'b0110, 32'h0000_0000, 0, 1);
    one("R4 io write cmd", 1, 4'b0011, 32'h0001_0001, 0, 1);
    one("R4 cmd 1110", 1, 4'b1110, 32'h0000_0000, 0, 1);
  endtask

  task automatic t_fields;
    one("R5 fields type1", 1, 4'b1010, 32'hAB5A_A6E9, 0, 1);
    one("R5 fields type0", 1, 4'b1011, 32'h00C3_F8FC, 0, 0);
  endtask

  task automatic t_func_ignored;
    one("R6 func bits 7 single", 1, 4'b1010, 32'h0000_0700, 0, 1);
    one("R6 func bits 5 single", 1, 4'b1011, 32'h0000_0514, 0, 1);
  endtask

  task automatic t_idle;
    one("R9 no strobe", 0, 4'b1010, 32'h0000_0000, 0, 1);
  endtask

  task automatic t_multi;
    for (int f = 0; f < 8; f++) begin
      logic [31:0] a;
      a = {21'h0, f[2:0], 8'h28};
      @(negedge clk); drive(1, 4'b1010, a, 0, 1);
      @(negedge clk); drive(0, 4'h0, 32'h0, 0, 0);
      check($sformatf("R11 multi-function func %0d", f),
        {vld_m, t0_m, t1_m, bad_m, dsel_m, rn_m, fn_m, dn_m, bn_m},
        model(1, 4'b1010, a, 0, 1, 4));
    end
  endtask

  task automatic t_back_to_back;
    logic [31:0] a1, a2, a3;
    a1 = 32'h0000_0048; a2 = 32'h0042_1B01; a3 = 32'h0000_00A0;
    @(negedge clk); drive(1, 4'b1010, a1, 0, 1);
    @(negedge clk); drive(1, 4'b1011, a2, 1, 1);
    check("R12 b2b first", {vld, t0, t1, bad, dsel, rn, fn, dn, bn}, model(1, 4'b1010, a1, 0, 1, 1));
    @(negedge clk); drive(1, 4'b1011, a3, 1, 1);
    check("R12 b2b second", {vld, t0, t1, bad, dsel, rn, fn, dn, bn}, model(1, 4'b1011, a2, 1, 1, 1));
    @(negedge clk); drive(1, 4'b1010, a1, 0, 1);
    check("R12 b2b third R8", {vld, t0, t1, bad, dsel, rn, fn, dn, bn}, model(1, 4'b1011, a3, 1, 1, 1));
    @(negedge clk); drive(0, 4'h0, 32'h0, 0, 0);
    check("R12 b2b fourth", {vld, t0, t1, bad, dsel, rn, fn, dn, bn}, model(1, 4'b1010, a1, 0, 1, 1));
    @(negedge clk);
    check("R9 R7 quiet after b2b", {vld, t0, t1, bad, dsel, rn, fn, dn, bn}, 27'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_type0();
    t_secondary();
    t_type1();
    t_bad();
    t_noncfg();
    t_fields();
    t_func_ignored();
    t_idle();
    t_multi();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule